// File: doc/BRIEF.md
# Watchdog Timer with Generation-Selected Control Masking

This block is a word-addressed watchdog. Software loads a reload value, then sets the enable bit in the control register. The down-counter then steps once per pulse on a 1 MHz tick-enable input. If software does not write a fixed restart code before the count runs out, the block raises a single-cycle timeout pulse and starts counting again from the reload value.

A build-time parameter selects one of three silicon generations. Each generation filters every control write differently: it clears some bits and may force others to one. The reset value of the control register passes through the same filter. The enable decision uses the filtered word. Only a change of the enable bit reloads or stops the counter. Any other control write is simply stored.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads as the filtered form of zero: 0x0 for generation 0, 0x10 for generation 1 and 0x0 for generation 2. The counter status and the reload value both read 0x03EF1480. The restart register reads 0. The reset-width register reads 0xFF.
- R2: A control write is stored through the generation filter.
  - Generation 0 keeps bits 15:0 and clears bits 31:16.
  - Generation 1 clears bits 11:8 and forces bit 4 (1 MHz clock select) to 1.
  - Generation 2 clears bits 9:7.
- R3: Word address map:
  - 0: control
  - 1: reload value
  - 2: restart
  - 3: counter status, which is read-only; writes to it are ignored
  - 4: reset width, where bits 7:0 are stored and the upper bits read 0
  - 5 to 7: read 0
  
  Read data is valid in the same cycle that valid is high and write is low.
- R4: A control write whose filtered bit 0 (enable) is 1 while the watchdog is disabled loads the counter from the reload register. The loaded value is visible in the next cycle.
- R5: While the watchdog is enabled, each tick pulse lowers a nonzero counter by exactly one.
- R6: A control write that leaves the enable bit unchanged still stores the filtered value. It neither reloads nor stops the counter.
- R7: A control write with enable 0 while the watchdog is enabled stops the counter. The count holds across later ticks, and also across a tick in the same cycle as that write.
- R8: Writing exactly 0x00004755 to the restart register reloads the counter. Any other value written there has no effect, and the restart register always reads 0.
- R9: A tick while enabled with the counter at 0 reloads the counter. It also drives the timeout output high for exactly one cycle, in the cycle after that tick.
- R10: When a valid restart write falls in the same cycle as an expiring tick, the restart wins. The counter reloads and no timeout pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (3) | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| tick_i | input | 1 | 1 MHz count enable pulse |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
Two events can fall in the same cycle: an expiring tick and a register write that also wants to set the counter. In the main case the write is a restart with the code. A disabling control write paired with a tick is a second such case. The bench provokes both by raising the tick and the bus write in one cycle. For the restart case the counter reload looks the same whichever event wins, so the result is judged on the timeout output: it must stay low. For the disable case it is judged on the counter, which must not move.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned DW          = 32;
    localparam int unsigned EN_BIT      = 0;
    localparam int unsigned CLKSEL_BIT  = 4;
    localparam logic [DW-1:0] CNT_RST   = 32'h03EF_1480;
    localparam logic [DW-1:0] RESTART_KEY = 32'h0000_4755;

    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_RELOAD = 1;
    localparam int unsigned A_KICK   = 2;
    localparam int unsigned A_COUNT  = 3;
    localparam int unsigned A_WIDTH  = 4;

    // Bits a generation always clears on a control write.
    function automatic logic [DW-1:0] ctl_clear_mask(input int gen);
        case (gen)
            0:       return 32'hFFFF_0000;
            1:       return 32'h0000_0F00;
            default: return 32'h0000_0380;
        endcase
    endfunction

    // Bits a generation always forces on a control write.
    function automatic logic [DW-1:0] ctl_set_mask(input int gen);
        return (gen == 1) ? (32'h1 << CLKSEL_BIT) : '0;
    endfunction
endpackage

// File: rtl/wdog_ctl_filter.sv
module wdog_ctl_filter
    import wdog_pkg::*;
#(
    parameter int GEN = 1
) (
    input  logic [DW-1:0] raw_i,
    output logic [DW-1:0] clean_o
);
    generate
        if (GEN == 0) begin : g_gen0
            assign clean_o = raw_i & 32'h0000_FFFF;
        end else if (GEN == 1) begin : g_gen1
            assign clean_o = (raw_i & ~32'h0000_0F00) | (32'h1 << CLKSEL_BIT);
        end else begin : g_gen2
            assign clean_o = raw_i & ~32'h0000_0380;
        end
    endgenerate
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int unsigned CNT_W = 32,
    parameter logic [CNT_W-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expire;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt    = load_val_i;
                st_d.expire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt    <= RST_VAL;
            st_q.expire <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign expire_o = st_q.expire;

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.cnt == $past(load_val_i))) else $error("load"); // R4

    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !load_i) |=> (st_q.cnt == $past(st_q.cnt))) else $error("hold"); // R7

    AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i && !load_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1))
        else $error("step"); // R5

    AST_EXPIRE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> $past(run_i && tick_i && !load_i)) else $error("expire"); // R9
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int          GEN     = 1,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned PULSE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic              tick_i,
    output logic              timeout_o
);
    localparam logic [DW-1:0]      CTRL_RST  = ctl_set_mask(GEN);
    localparam logic [DW-1:0]      CLR_MASK  = ctl_clear_mask(GEN);
    localparam logic [DW-1:0]      SET_MASK  = ctl_set_mask(GEN);
    localparam logic [PULSE_W-1:0] WIDTH_RST = '1;

    typedef struct packed {
        logic [DW-1:0]      ctrl;
        logic [DW-1:0]      reload;
        logic [PULSE_W-1:0] width;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [DW-1:0] ctl_clean;
    logic [DW-1:0] cnt_val;
    logic          wr_en, cnt_load, cnt_run;

    wdog_ctl_filter #(.GEN(GEN)) u_filter (
        .raw_i   (bus_wdata_i),
        .clean_o (ctl_clean)
    );

    assign wr_en = bus_valid_i && bus_write_i;

    always_comb begin
        rg_d     = rg_q;
        cnt_load = 1'b0;
        if (wr_en) begin
            case (bus_addr_i)
                ADDR_W'(A_CTRL): begin
                    rg_d.ctrl = ctl_clean;
                    cnt_load  = ctl_clean[EN_BIT] && !rg_q.ctrl[EN_BIT];
                end
                ADDR_W'(A_RELOAD): rg_d.reload = bus_wdata_i;
                ADDR_W'(A_KICK):   cnt_load    = (bus_wdata_i == RESTART_KEY);
                ADDR_W'(A_WIDTH):  rg_d.width  = bus_wdata_i[PULSE_W-1:0];
                default: ;
            endcase
        end
        cnt_run = rg_q.ctrl[EN_BIT] && rg_d.ctrl[EN_BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q.ctrl   <= CTRL_RST;
            rg_q.reload <= CNT_RST;
            rg_q.width  <= WIDTH_RST;
        end else begin
            rg_q <= rg_d;
        end
    end

    wdog_down_counter #(.CNT_W(DW), .RST_VAL(CNT_RST)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (cnt_run),
        .tick_i     (tick_i),
        .load_i     (cnt_load),
        .load_val_i (rg_q.reload),
        .cnt_o      (cnt_val),
        .expire_o   (timeout_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_valid_i && !bus_write_i) begin
            case (bus_addr_i)
                ADDR_W'(A_CTRL):   bus_rdata_o = rg_q.ctrl;
                ADDR_W'(A_RELOAD): bus_rdata_o = rg_q.reload;
                ADDR_W'(A_COUNT):  bus_rdata_o = cnt_val;
                ADDR_W'(A_WIDTH):  bus_rdata_o = DW'(rg_q.width);
                default:           bus_rdata_o = '0;
            endcase
        end
    end

    AST_CTRL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rg_q.ctrl & CLR_MASK) == '0) && ((rg_q.ctrl & SET_MASK) == SET_MASK))
        else $error("ctrl mask"); // R2

    AST_KICK_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en && bus_addr_i == ADDR_W'(A_KICK) && bus_wdata_i == RESTART_KEY)
        |=> (cnt_val == $past(rg_q.reload) && !timeout_o)) else $error("kick"); // R10
endmodule

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, write = 1'b0, tick = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata [3];
    logic        tmo [3];
    int          errors = 0, checks = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    wdog_timer #(.GEN(0)) dut_g0 (.clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid),
        .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata[0]), .tick_i(tick), .timeout_o(tmo[0]));
    wdog_timer #(.GEN(1)) dut_i (.clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid),
        .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata[1]), .tick_i(tick), .timeout_o(tmo[1]));
    wdog_timer #(.GEN(2)) dut_g2 (.clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid),
        .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata[2]), .tick_i(tick), .timeout_o(tmo[2]));

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data against the scoreboard mid-cycle.
    always @(negedge clk) begin
        if (valid && !write && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(it.tag, rdata[it.sel], it.exp);
        end
    end

    task automatic rd(int sel, logic [2:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #2;
        valid = 1'b1; write = 1'b0; addr = a;
        exp_q.push_back('{sel: sel, exp: exp, tag: tag});
        @(posedge clk); #2;
        valid = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, bit with_tick);
        @(posedge clk); #2;
        valid = 1'b1; write = 1'b1; addr = a; wdata = d; tick = with_tick;
        @(posedge clk); #2;
        valid = 1'b0; write = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2; tick = 1'b1;
            @(posedge clk); #2; tick = 1'b0;
        end
    endtask

    task automatic tick_chk(logic exp, string tag);
        @(posedge clk); #2; tick = 1'b1;
        @(posedge clk); #2; tick = 1'b0;
        @(negedge clk);
        check(tag, 32'(tmo[1]), 32'(exp));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(1, 3'd0, 32'h10, "R1 ctrl gen1");
        rd(0, 3'd0, 32'h0, "R1 ctrl gen0");
        rd(2, 3'd0, 32'h0, "R1 ctrl gen2");
        rd(1, 3'd3, 32'h03EF1480, "R1 counter");
        rd(1, 3'd1, 32'h03EF1480, "R1 reload");
        rd(1, 3'd2, 32'h0, "R1 restart");
        rd(1, 3'd4, 32'hFF, "R1 width");

        // R2 generation filters
        wr(3'd0, 32'hFFFF_FFFE, 0);
        rd(1, 3'd0, 32'hFFFF_F0FE, "R2 gen1");
        rd(0, 3'd0, 32'h0000_FFFE, "R2 gen0");
        rd(2, 3'd0, 32'hFFFF_FC7E, "R2 gen2");

        // R3 map
        wr(3'd3, 32'h77, 0);
        rd(1, 3'd3, 32'h03EF1480, "R3 counter read-only");
        wr(3'd4, 32'h1234, 0);
        rd(1, 3'd4, 32'h34, "R3 width bits");
        rd(1, 3'd6, 32'h0, "R3 unmapped");

        // R4 enable reloads
        wr(3'd1, 32'd5, 0);
        wr(3'd0, 32'h1, 0);
        rd(1, 3'd0, 32'h11, "R4 ctrl");
        rd(1, 3'd3, 32'd5, "R4 counter loaded");

        // R5 decrement
        ticks(3);
        rd(1, 3'd3, 32'd2, "R5 after 3 ticks");

        // R6 write without enable change
        wr(3'd0, 32'h41, 0);
        rd(1, 3'd0, 32'h51, "R6 ctrl stored");
        rd(1, 3'd3, 32'd2, "R6 no reload");

        // R7 disable, tick in same cycle, then more ticks
        wr(3'd0, 32'h0, 1);
        rd(1, 3'd3, 32'd2, "R7 disable with tick");
        ticks(2);
        rd(1, 3'd3, 32'd2, "R7 held");
        wr(3'd0, 32'h20, 0);
        rd(1, 3'd0, 32'h30, "R6 stored while disabled");

        // R8 restart
        wr(3'd0, 32'h1, 0);
        ticks(2);
        rd(1, 3'd3, 32'd3, "R5 count 3");
        wr(3'd2, 32'h1234, 0);
        rd(1, 3'd3, 32'd3, "R8 wrong key ignored");
        wr(3'd2, 32'h4755, 0);
        rd(1, 3'd3, 32'd5, "R8 key reloads");
        rd(1, 3'd2, 32'h0, "R8 restart reads 0");

        // R9 expiry
        for (int i = 0; i < 5; i++) tick_chk(1'b0, "R9 no early timeout");
        rd(1, 3'd3, 32'd0, "R5 reached zero");
        tick_chk(1'b1, "R9 timeout pulse");
        @(negedge clk);
        check("R9 pulse one cycle", 32'(tmo[1]), 32'h0);
        rd(1, 3'd3, 32'd5, "R9 reloaded");

        // R10 restart vs expiring tick
        ticks(5);
        rd(1, 3'd3, 32'd0, "R10 at zero");
        wr(3'd2, 32'h4755, 1);
        @(negedge clk);
        check("R10 no timeout", 32'(tmo[1]), 32'h0);
        rd(1, 3'd3, 32'd5, "R10 reloaded");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
        end
        summary();
    end
endmodule